// File: doc/BRIEF.md
# Delayed Read Tracker

This block follows a single deferred read through a bridge between two buses. The first read attempt from the initiator side is answered with retry, and the block records its address, command and byte enables. When an ordering-permission input allows it, the block asks the target side to perform the read. It counts back-to-back retries from the target. It records whether the read completed with data or with an abort, together with a handle that points at the data. Later initiator attempts are compared with the recorded entry and answered with retry, data or target abort.

Two watchdogs can drop the entry. The first is a long limit on back-to-back target retries. The second is a wait for the initiator to return, which starts once a completion is stored and has a selectable length. Either one raises an error strobe when error reporting is enabled. Ordering rules, the data buffer and the bus pin drivers are outside this block. They are seen here only as the permission inputs and the target request/result handshake.

Top module: `dly_read_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the entry is empty and rsp_valid, tgt_req and err_pulse are all 0.
- R2: An attempt (ini_valid high) that arrives while the entry is empty is recorded and answered with retry.
- R3: tgt_req is high only while a recorded read is still waiting for its target-side result and ord_launch_ok is high. While it is high, tgt_addr, tgt_cmd and tgt_be carry the recorded values.
- R4: An attempt sampled at a clock edge gets its answer in the following cycle, and in no other cycle. The answer is rsp_valid = 1 with rsp_code 2'b01 for retry, 2'b10 for data (with rsp_tag holding the stored handle) or 2'b11 for target abort.
- R5: An attempt that is not a memory read matches only if its address, command and byte enables all equal the recorded ones.
- R6: The memory-read commands 4'b0110, 4'b1100 and 4'b1110 are treated as the same command. Two attempts that both use one of these commands match when their addresses are equal, whatever their byte enables.
- R7: When a completion is stored and a matching attempt arrives while ord_return_ok is low, the attempt is answered with retry and the completion is kept.
- R8: While the entry is busy, an attempt that does not match is answered with retry and the recorded entry does not change.
- R9: The target reports a result with tgt_status: 2'b00 means data, 2'b01 means retry, and 2'b10 or 2'b11 means abort. On the 2^RETRY_LOG2-th back-to-back target retry the entry is discarded and tgt_req drops. In the next cycle err_pulse is high for one cycle if cfg_serr_en is set.
- R10: While cfg_retry_cnt_dis is high, target retries never discard the entry.
- R11: Once an entry has been discarded before its completion arrived, a matching attempt is answered with target abort and the entry becomes empty.
- R12: Once a completion is stored, it is dropped if no matching attempt is served within 2^MTO_SHORT_LOG2 clock cycles (cfg_mto_long = 0) or 2^MTO_LONG_LOG2 clock cycles (cfg_mto_long = 1). When it is dropped, err_pulse is high for one cycle if cfg_serr_en is set, and a later attempt starts a new entry. An attempt served at the last counted edge still receives its data.
- R13: While cfg_mto_dis is high, a stored completion is never dropped for lack of a return.
- R14: A matching attempt served from a completion stored with a data status receives data with the stored tag. A completion stored with an abort status gives target abort. Either way the entry becomes empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_retry_cnt_dis | input | 1 | Turns off the target-retry limit |
| cfg_mto_long | input | 1 | Selects the long return wait |
| cfg_mto_dis | input | 1 | Turns off the return-wait discard |
| cfg_serr_en | input | 1 | Allows err_pulse |
| ini_valid | input | 1 | Initiator attempt present this cycle |
| ini_addr | input | ADDR_W | Attempt address |
| ini_cmd | input | 4 | Attempt bus command |
| ini_be | input | 4 | Attempt byte enables |
| rsp_valid | output | 1 | Answer to last cycle's attempt |
| rsp_code | output | 2 | 01 retry, 10 data, 11 target abort |
| rsp_tag | output | TAG_W | Data handle with a data answer |
| ord_launch_ok | input | 1 | Ordering allows starting the target read |
| ord_return_ok | input | 1 | Ordering allows returning the completion |
| tgt_req | output | 1 | Request for the target-side read |
| tgt_addr | output | ADDR_W | Recorded address |
| tgt_cmd | output | 4 | Recorded command |
| tgt_be | output | 4 | Recorded byte enables |
| tgt_done | input | 1 | Target result present |
| tgt_status | input | 2 | 00 data, 01 retry, 1x abort |
| tgt_tag | input | TAG_W | Data handle for a data result |
| err_pulse | output | 1 | One-cycle error report |

## Verification
Some properties are checked by assertions on every cycle. Each attempt gets exactly one answer in the next cycle, and a data answer is only given when return permission was present. The error strobe only fires when reporting is enabled. A served entry is always left empty, and the recorded request stays fixed while the entry is busy. Both counters stay frozen or below their selected limits. Other behaviour can only be shown by the bench's scenarios. These are the exact cycle on which each watchdog expires, the aliasing of memory-read commands across all command pairs, and the abort given for an entry discarded before its completion arrived.

// File: rtl/dr_pkg.sv
// Package dr_pkg: shared encodings for the delayed read tracker.
// Assumes 4-bit bus commands with the usual memory-read code points.
package dr_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY     = 2'b00,
        ST_REQUESTED = 2'b01,
        ST_COMPLETED = 2'b10,
        ST_DISCARDED = 2'b11
    } entry_state_e;

    typedef enum logic [1:0] {
        ANS_NONE  = 2'b00,
        ANS_RETRY = 2'b01,
        ANS_DATA  = 2'b10,
        ANS_ABORT = 2'b11
    } answer_e;

    localparam logic [1:0] TST_DATA  = 2'b00;
    localparam logic [1:0] TST_RETRY = 2'b01;

    localparam logic [3:0] CMD_MRD  = 4'b0110;
    localparam logic [3:0] CMD_MRDM = 4'b1100;
    localparam logic [3:0] CMD_MRDL = 4'b1110;

    // True for any of the three memory read command variants.
    function automatic logic is_mem_read(input logic [3:0] cmd);
        return (cmd == CMD_MRD) || (cmd == CMD_MRDM) || (cmd == CMD_MRDL);
    endfunction

endpackage

// File: rtl/dr_match.sv
// Module dr_match: decides whether an initiator attempt repeats the
// recorded request. Memory read variants alias and compare address only;
// every other command needs address, command and byte enables equal.
// Purely combinational; the caller qualifies the result with its state.
module dr_match #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] ent_addr,
    input  logic [3:0]        ent_cmd,
    input  logic [3:0]        ent_be,
    input  logic [ADDR_W-1:0] att_addr,
    input  logic [3:0]        att_cmd,
    input  logic [3:0]        att_be,
    output logic              hit
);
    import dr_pkg::*;

    logic addr_eq;
    logic both_mrd;
    logic exact_eq;

    // Compare the fields and pick the aliasing rule.
    always_comb begin
        addr_eq  = (ent_addr == att_addr);
        both_mrd = is_mem_read(ent_cmd) && is_mem_read(att_cmd);
        exact_eq = (ent_cmd == att_cmd) && (ent_be == att_be);
        hit      = addr_eq && (both_mrd || exact_eq);
    end

endmodule

// File: rtl/dr_retry_cnt.sv
// Module dr_retry_cnt: counts back-to-back target retries for the entry
// and flags the retry that reaches 2^LOG2. Assumes clear is held while no
// target read is outstanding. When disabled, the count stays at zero.
module dr_retry_cnt #(
    parameter int LOG2 = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic retry_seen,
    input  logic cfg_dis,
    output logic limit_hit
);
    localparam logic [LOG2-1:0] CNT_MAX = {LOG2{1'b1}};

    logic [LOG2-1:0] cnt;

    // Flag the retry that would carry the count past its maximum.
    always_comb begin
        limit_hit = retry_seen && !cfg_dis && (cnt == CNT_MAX);
    end

    // Advance the count on each retry; clear it when idle or disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || cfg_dis) begin
            cnt <= '0;
        end else if (retry_seen) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_RETRY_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_dis) |-> (cnt == '0)) else $error("retry count moved while disabled"); // R10

    AST_RETRY_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !cfg_dis && !retry_seen) |=> $stable(cnt)) else $error("retry count moved without a retry"); // R9

endmodule

// File: rtl/dr_mto_timer.sv
// Module dr_mto_timer: measures how long a stored completion waits for
// its initiator. expire is high in the cycle whose edge completes
// 2^SHORT_LOG2 or 2^LONG_LOG2 waiting cycles. Assumes run is high only
// while a completion is stored; the count restarts whenever run drops.
module dr_mto_timer #(
    parameter int SHORT_LOG2 = 10,
    parameter int LONG_LOG2  = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic sel_long,
    input  logic cfg_dis,
    output logic expire
);
    localparam int CW = LONG_LOG2 + 1;
    localparam logic [CW-1:0] LIM_SHORT = CW'(1) << SHORT_LOG2;
    localparam logic [CW-1:0] LIM_LONG  = CW'(1) << LONG_LOG2;

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    // Select the wait length and detect its last cycle.
    always_comb begin
        limit  = sel_long ? LIM_LONG : LIM_SHORT;
        expire = run && !cfg_dis && (cnt >= limit - 1'b1);
    end

    // Count waiting cycles while a completion is stored.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (!expire) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_MTO_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!run) |-> (cnt == '0)) else $error("wait timer not restarted"); // R12

    AST_MTO_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_dis && $past(!cfg_dis) && $stable(sel_long)) |-> (cnt < limit)) else $error("wait timer overran"); // R12

endmodule

// File: rtl/dly_read_ctrl.sv
// Module dly_read_ctrl: holds one delayed read entry, drives the target
// request under ordering permission, watches both discard timers, and
// answers every initiator attempt one cycle after it is sampled.
// Assumes tgt_done is only meaningful while tgt_req is high, and that
// ini_valid marks one attempt per high cycle.
module dly_read_ctrl #(
    parameter int ADDR_W          = 32,
    parameter int TAG_W           = 4,
    parameter int RETRY_LOG2      = 24,
    parameter int MTO_SHORT_LOG2  = 10,
    parameter int MTO_LONG_LOG2   = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_retry_cnt_dis,
    input  logic              cfg_mto_long,
    input  logic              cfg_mto_dis,
    input  logic              cfg_serr_en,
    input  logic              ini_valid,
    input  logic [ADDR_W-1:0] ini_addr,
    input  logic [3:0]        ini_cmd,
    input  logic [3:0]        ini_be,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic [TAG_W-1:0]  rsp_tag,
    input  logic              ord_launch_ok,
    input  logic              ord_return_ok,
    output logic              tgt_req,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [3:0]        tgt_cmd,
    output logic [3:0]        tgt_be,
    input  logic              tgt_done,
    input  logic [1:0]        tgt_status,
    input  logic [TAG_W-1:0]  tgt_tag,
    output logic              err_pulse
);
    import dr_pkg::*;

    entry_state_e      state_q, state_d;
    logic [ADDR_W-1:0] ent_addr_q;
    logic [3:0]        ent_cmd_q;
    logic [3:0]        ent_be_q;
    logic [TAG_W-1:0]  ent_tag_q;
    logic              ent_abort_q;

    logic              hit;
    logic              retry_seen;
    logic              retry_limit;
    logic              mto_expire;
    logic              tgt_result;

    logic              latch_req;
    logic              store_cpl;
    logic              store_abort;
    answer_e           ans_d;
    logic              err_d;

    dr_match #(.ADDR_W(ADDR_W)) u_match (
        .ent_addr (ent_addr_q),
        .ent_cmd  (ent_cmd_q),
        .ent_be   (ent_be_q),
        .att_addr (ini_addr),
        .att_cmd  (ini_cmd),
        .att_be   (ini_be),
        .hit      (hit)
    );

    dr_retry_cnt #(.LOG2(RETRY_LOG2)) u_retry (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (state_q != ST_REQUESTED),
        .retry_seen (retry_seen),
        .cfg_dis    (cfg_retry_cnt_dis),
        .limit_hit  (retry_limit)
    );

    dr_mto_timer #(.SHORT_LOG2(MTO_SHORT_LOG2), .LONG_LOG2(MTO_LONG_LOG2)) u_mto (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state_q == ST_COMPLETED),
        .sel_long (cfg_mto_long),
        .cfg_dis  (cfg_mto_dis),
        .expire   (mto_expire)
    );

    // Present the recorded request to the target side under permission.
    always_comb begin
        tgt_req    = (state_q == ST_REQUESTED) && ord_launch_ok;
        tgt_addr   = ent_addr_q;
        tgt_cmd    = ent_cmd_q;
        tgt_be     = ent_be_q;
        tgt_result = tgt_req && tgt_done;
        retry_seen = tgt_result && (tgt_status == TST_RETRY);
    end

    // Decide next state, answer and error report for this cycle.
    always_comb begin
        state_d     = state_q;
        latch_req   = 1'b0;
        store_cpl   = 1'b0;
        store_abort = 1'b0;
        ans_d       = ANS_NONE;
        err_d       = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                if (ini_valid) begin
                    latch_req = 1'b1;
                    ans_d     = ANS_RETRY;
                    state_d   = ST_REQUESTED;
                end
            end
            ST_REQUESTED: begin
                if (ini_valid) begin
                    ans_d = ANS_RETRY;
                end
                if (tgt_result) begin
                    if (tgt_status == TST_DATA) begin
                        store_cpl = 1'b1;
                        state_d   = ST_COMPLETED;
                    end else if (tgt_status == TST_RETRY) begin
                        if (retry_limit) begin
                            state_d = ST_DISCARDED;
                            err_d   = cfg_serr_en;
                        end
                    end else begin
                        store_cpl   = 1'b1;
                        store_abort = 1'b1;
                        state_d     = ST_COMPLETED;
                    end
                end
            end
            ST_COMPLETED: begin
                if (ini_valid && hit && ord_return_ok) begin
                    ans_d   = ent_abort_q ? ANS_ABORT : ANS_DATA;
                    state_d = ST_EMPTY;
                end else begin
                    if (ini_valid) begin
                        ans_d = ANS_RETRY;
                    end
                    if (mto_expire) begin
                        state_d = ST_EMPTY;
                        err_d   = cfg_serr_en;
                    end
                end
            end
            ST_DISCARDED: begin
                if (ini_valid) begin
                    if (hit) begin
                        ans_d   = ANS_ABORT;
                        state_d = ST_EMPTY;
                    end else begin
                        ans_d = ANS_RETRY;
                    end
                end
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // Entry state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Record the request fields when a new entry opens.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_addr_q <= '0;
            ent_cmd_q  <= '0;
            ent_be_q   <= '0;
        end else if (latch_req) begin
            ent_addr_q <= ini_addr;
            ent_cmd_q  <= ini_cmd;
            ent_be_q   <= ini_be;
        end
    end

    // Record the completion handle and its status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_tag_q   <= '0;
            ent_abort_q <= 1'b0;
        end else if (store_cpl) begin
            ent_tag_q   <= store_abort ? '0 : tgt_tag;
            ent_abort_q <= store_abort;
        end
    end

    // Register the answer and the error strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_code  <= ANS_NONE;
            rsp_tag   <= '0;
            err_pulse <= 1'b0;
        end else begin
            rsp_valid <= (ans_d != ANS_NONE);
            rsp_code  <= ans_d;
            rsp_tag   <= (ans_d == ANS_DATA) ? ent_tag_q : '0;
            err_pulse <= err_d;
        end
    end

    AST_RSP_FOLLOWS_ATTEMPT: assert property (@(posedge clk) disable iff (!rst_n)
        ini_valid |=> rsp_valid) else $error("attempt left unanswered"); // R4

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !ini_valid |=> !rsp_valid) else $error("answer without attempt"); // R4

    AST_DATA_NEEDS_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == ANS_DATA) |-> $past(ord_return_ok)) else $error("data returned without permission"); // R7

    AST_ERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(cfg_serr_en)) else $error("error strobe while reporting off"); // R9

    AST_SERVE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_code == ANS_DATA || rsp_code == ANS_ABORT)) |-> (state_q == ST_EMPTY)) else $error("served entry not emptied"); // R11

    AST_ENTRY_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_EMPTY && $past(state_q != ST_EMPTY)) |-> ($stable(ent_addr_q) && $stable(ent_cmd_q) && $stable(ent_be_q))) else $error("busy entry changed"); // R8

    AST_REQ_DROPS_ON_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DISCARDED) |-> !tgt_req) else $error("request after discard"); // R9

endmodule

// File: tb/sim_dly_read_ctrl.sv
module sim_dly_read_ctrl;
    localparam int AW = 8;
    localparam int TW = 4;
    localparam int RL = 3;
    localparam int MS = 2;
    localparam int ML = 4;
    localparam int RETRY_LIM = 1 << RL;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_retry_cnt_dis = 1'b0, cfg_mto_long = 1'b1, cfg_mto_dis = 1'b0, cfg_serr_en = 1'b1;
    logic ini_valid = 1'b0;
    logic [AW-1:0] ini_addr = '0;
    logic [3:0] ini_cmd = '0, ini_be = '0;
    logic rsp_valid;
    logic [1:0] rsp_code;
    logic [TW-1:0] rsp_tag;
    logic ord_launch_ok = 1'b0, ord_return_ok = 1'b1;
    logic tgt_req;
    logic [AW-1:0] tgt_addr;
    logic [3:0] tgt_cmd, tgt_be;
    logic tgt_done = 1'b0;
    logic [1:0] tgt_status = '0;
    logic [TW-1:0] tgt_tag = '0;
    logic err_pulse;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    dly_read_ctrl #(.ADDR_W(AW), .TAG_W(TW), .RETRY_LOG2(RL),
                    .MTO_SHORT_LOG2(MS), .MTO_LONG_LOG2(ML)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_retry_cnt_dis(cfg_retry_cnt_dis), .cfg_mto_long(cfg_mto_long),
        .cfg_mto_dis(cfg_mto_dis), .cfg_serr_en(cfg_serr_en),
        .ini_valid(ini_valid), .ini_addr(ini_addr), .ini_cmd(ini_cmd), .ini_be(ini_be),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_tag(rsp_tag),
        .ord_launch_ok(ord_launch_ok), .ord_return_ok(ord_return_ok),
        .tgt_req(tgt_req), .tgt_addr(tgt_addr), .tgt_cmd(tgt_cmd), .tgt_be(tgt_be),
        .tgt_done(tgt_done), .tgt_status(tgt_status), .tgt_tag(tgt_tag),
        .err_pulse(err_pulse)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit mrd(input logic [3:0] c);
        return c == 4'd6 || c == 4'd12 || c == 4'd14;
    endfunction

    function automatic bit exp_hit(input logic [AW-1:0] a1, input logic [3:0] c1, input logic [3:0] b1,
                                   input logic [AW-1:0] a2, input logic [3:0] c2, input logic [3:0] b2);
        if (mrd(c1) && mrd(c2)) return a1 == a2;
        return a1 == a2 && c1 == c2 && b1 == b2;
    endfunction

    // One attempt; returns the answer code seen in the following cycle (0 if none).
    task automatic attempt(input logic [AW-1:0] a, input logic [3:0] c, input logic [3:0] b,
                           output logic [1:0] code, output logic [TW-1:0] tag);
        ini_valid = 1'b1; ini_addr = a; ini_cmd = c; ini_be = b;
        @(posedge clk); @(negedge clk);
        ini_valid = 1'b0;
        code = rsp_valid ? rsp_code : 2'b00;
        tag = rsp_tag;
    endtask

    task automatic tresult(input logic [1:0] st, input logic [TW-1:0] tg);
        tgt_done = 1'b1; tgt_status = st; tgt_tag = tg;
        @(posedge clk); @(negedge clk);
        tgt_done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [1:0] code;
        logic [TW-1:0] tag;
        bit disc;
        int lim;
        int ws[5];

        repeat (3) @(negedge clk);
        // R1 reset state
        check(rsp_valid == 0 && tgt_req == 0 && err_pulse == 0, "R1", {rsp_valid, tgt_req, err_pulse}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid == 0, "R4 idle", rsp_valid, 0);

        // R2 / R3: record and launch only with permission
        attempt(8'h3C, 4'd2, 4'h5, code, tag);
        check(code == 2'b01, "R2", code, 1);
        repeat (2) @(negedge clk);
        check(tgt_req == 0, "R3 no permission", tgt_req, 0);
        ord_launch_ok = 1'b1; #1;
        check(tgt_req == 1, "R3 permitted", tgt_req, 1);
        check(tgt_addr == 8'h3C && tgt_cmd == 4'd2 && tgt_be == 4'h5, "R3 fields", {tgt_addr, tgt_cmd, tgt_be}, {8'h3C, 4'd2, 4'h5});
        // R8: non-match while requested
        attempt(8'h11, 4'd2, 4'h5, code, tag);
        check(code == 2'b01, "R8 busy", code, 1);
        check(tgt_addr == 8'h3C, "R8 entry kept", tgt_addr, 8'h3C);
        // R7 ordering blocks return
        tresult(2'b00, 4'h9);
        ord_return_ok = 1'b0;
        attempt(8'h3C, 4'd2, 4'h5, code, tag);
        check(code == 2'b01, "R7 held", code, 1);
        ord_return_ok = 1'b1;
        attempt(8'h3C, 4'd2, 4'h5, code, tag);
        check(code == 2'b10, "R7 then data", code, 2);
        check(tag == 4'h9, "R14 tag", tag, 9);
        @(negedge clk);
        check(rsp_valid == 0, "R4 single answer", rsp_valid, 0);

        // R14 abort status
        attempt(8'h40, 4'd10, 4'hF, code, tag);
        tresult(2'b10, 4'h3);
        attempt(8'h40, 4'd10, 4'hF, code, tag);
        check(code == 2'b11, "R14 abort", code, 3);

        // R5 / R6 / R8 sweep over command pairs
        for (int c1 = 0; c1 < 16; c1++) begin
            for (int c2 = 0; c2 < 16; c2++) begin
                logic [3:0] b2;
                logic [AW-1:0] a2;
                bit h;
                b2 = (c2 % 3 == 0) ? 4'hC : 4'h3;
                a2 = (c2 == 5) ? 8'h81 : 8'h80;
                h = exp_hit(8'h80, 4'(c1), 4'h3, a2, 4'(c2), b2);
                attempt(8'h80, 4'(c1), 4'h3, code, tag);
                check(code == 2'b01, "R2 sweep", code, 1);
                tresult(2'b00, 4'(c2));
                attempt(a2, 4'(c2), b2, code, tag);
                check(code == (h ? 2'b10 : 2'b01), (mrd(4'(c1)) && mrd(4'(c2))) ? "R6" : "R5", code, h ? 2 : 1);
                if (!h) begin
                    attempt(8'h80, 4'(c1), 4'h3, code, tag);
                    check(code == 2'b10, "R8 entry unchanged", code, 2);
                end
            end
        end

        // R9 / R10 / R11 retry-limit sweep
        for (int dis = 0; dis < 2; dis++) begin
            for (int n = 0; n <= 10; n++) begin
                cfg_retry_cnt_dis = dis[0];
                cfg_serr_en = (n != 9);
                disc = 0;
                attempt(8'h22, 4'd3, 4'h1, code, tag);
                for (int k = 1; k <= n; k++) begin
                    if (!disc) begin
                        tresult(2'b01, 4'h0);
                        check(err_pulse == (dis == 0 && k == RETRY_LIM && n != 9), dis ? "R10" : "R9",
                              err_pulse, dis == 0 && k == RETRY_LIM && n != 9);
                        if (dis == 0 && k == RETRY_LIM) begin
                            disc = 1;
                            check(tgt_req == 0, "R9 req drops", tgt_req, 0);
                        end
                    end
                end
                if (disc) begin
                    if (n == 10) begin
                        attempt(8'h23, 4'd3, 4'h1, code, tag);
                        check(code == 2'b01, "R8 discarded", code, 1);
                    end
                    attempt(8'h22, 4'd3, 4'h1, code, tag);
                    check(code == 2'b11, "R11", code, 3);
                end else begin
                    tresult(2'b00, 4'h6);
                    attempt(8'h22, 4'd3, 4'h1, code, tag);
                    check(code == 2'b10, dis ? "R10 data" : "R9 below limit", code, 2);
                end
            end
        end
        cfg_retry_cnt_dis = 1'b0;
        cfg_serr_en = 1'b1;

        // R12 / R13 return-wait sweep
        for (int lg = 0; lg < 2; lg++) begin
            for (int dis = 0; dis < 2; dis++) begin
                cfg_mto_long = lg[0];
                cfg_mto_dis = dis[0];
                lim = lg ? (1 << ML) : (1 << MS);
                ws = '{0, lim - 2, lim - 1, lim, lim + 3};
                foreach (ws[i]) begin
                    attempt(8'h55, 4'd14, 4'h0, code, tag);
                    tresult(2'b00, 4'h5);
                    for (int k = 1; k <= ws[i]; k++) begin
                        @(negedge clk);
                        check(err_pulse == (dis == 0 && k == lim), dis ? "R13" : "R12", err_pulse, dis == 0 && k == lim);
                    end
                    attempt(8'h55, 4'd12, 4'hF, code, tag);
                    if (dis == 1 || ws[i] <= lim - 1) begin
                        check(code == 2'b10, dis ? "R13 kept" : "R12 in time", code, 2);
                    end else begin
                        check(code == 2'b01, "R12 dropped", code, 1);
                        tresult(2'b00, 4'h5);
                        attempt(8'h55, 4'd12, 4'hF, code, tag);
                        check(code == 2'b10, "R12 new entry", code, 2);
                    end
                end
            end
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule